// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block sits in a small programmable-logic device next to an FPGA and loads a configuration bitstream into it over a slave-serial link. A host starts a load with a one-cycle start pulse. The sequencer then holds the program pin inactive for a power-up interval and pulls it low so that the target clears its configuration memory. It waits for the target's init pin to signal that the clear has finished. It then shifts the bitstream out one bit per configuration clock, taking bytes from a valid/ready byte source.

After the last byte it issues a set number of extra configuration clocks so that the target can run its startup. It then judges the result from the done pin. If init falls while data is being loaded, the load is aborted at once. The interval waits and both timeouts count a microsecond tick, which is derived from the system clock by a parameter. Init and done pass through a two-flop synchroniser before any decision uses them. The host reads busy, success, failure and a two-bit error code.

Top module: `cfg_loader`

## Requirements
- R1: After an accepted start, `prog_o` stays high for at least HOLD_US×CLK_PER_US clock cycles and falls within three cycles after that.
- R2: With `prog_o` low, the sequencer waits until the synchronised init has been seen low and then high. Only then does it raise `prog_o` and begin loading.
- R3: Each bit is sent in two phases of HALF_CLKS cycles each. `cclk_o` is low with the bit on `din_o`, then high with `din_o` unchanged for the whole high phase.
- R4: Bytes go out most-significant bit first, 8 rising edges per byte. `byte_ready_o` is high only in the load phase with no byte in flight, so a byte is accepted only when the count of rising edges is a multiple of 8.
- R5: After the byte marked last, exactly TAIL_CLKS further rising edges are issued, with `din_o` high on each.
- R6: When done goes high within DONE_TO_US microseconds of the end of the tail clocks, `ok_o` rises, `busy_o` falls and `err_code_o` is 0.
- R7: If init goes low during the load phase, the sequencer ends in failure with `err_code_o` = 2. No further rising edge of `cclk_o` occurs, and no tail clocks are sent, even when the drop coincides with the last bit.
- R8: If init has not risen within INIT_TO_US microseconds of `prog_o` falling, the sequencer fails with `err_code_o` = 1 and sends no clocks.
- R9: If done is still low DONE_TO_US microseconds after the tail clocks, the sequencer fails with `err_code_o` = 3.
- R10: After reset, `busy_o`, `ok_o`, `fail_o`, `cclk_o` and `byte_ready_o` are low, `prog_o` is high and `err_code_o` is 0. A success or failure status is held, with `busy_o` low, until the next start.
- R11: A start pulse that arrives while `busy_o` is high is ignored: `prog_o` does not fall again and the load in progress completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a load |
| byte_valid_i | input | 1 | Byte source has a byte |
| byte_data_i | input | 8 | Bitstream byte |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_ready_o | output | 1 | Sequencer accepts the offered byte this cycle |
| init_i | input | 1 | Target init pin (asynchronous) |
| done_i | input | 1 | Target done pin (asynchronous) |
| prog_o | output | 1 | Target program pin; low requests a clear |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |
| err_code_o | output | 2 | 0 none, 1 init never rose, 2 init fell during load, 3 done stayed low |

## Verification
Two events can fall in the same cycle: the end of the final byte, which would start the tail clocks, and the arrival through the synchroniser of a falling init, which must abort the load. The bench provokes this by dropping init on the eighth rising edge of the last byte, so that the synchronised level lands while that bit's high phase is ending. The outcome is judged at the ports: error code 2, no tail clocks, and no clock edge after the drop. Random loads of differing lengths, byte gaps and target delays are checked around this directed case.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_CLEAR,
    ST_LOAD,
    ST_TAIL,
    ST_CHECK,
    ST_PASS,
    ST_FAIL
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_NONE         = 2'd0,
    ERR_INIT_TIMEOUT = 2'd1,
    ERR_INIT_DROP    = 2'd2,
    ERR_DONE_LOW     = 2'd3
  } cfg_err_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/cfg_us_timer.sv
module cfg_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int UW         = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [UW-1:0] limit_i,
  output logic          expired_o
);
  localparam int PW = $clog2(CLK_PER_US + 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q == PW'(CLK_PER_US - 1)) begin
      pre_q <= '0;
      if (us_q != '1) us_q <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign expired_o = (us_q >= limit_i);

  // microsecond count advances by at most one per cycle
  p_us_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (us_q - $past(us_q)) <= UW'(1));
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int HALF_CLKS = 2,
  parameter int CW        = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      load_i,
  input  logic [cfg_pkg::BYTE_W-1:0] data_i,
  input  logic [CW-1:0]             nclk_i,
  output logic                      active_o,
  output logic                      cclk_o,
  output logic                      din_o
);
  localparam int BW = cfg_pkg::BYTE_W;
  localparam int HW = $clog2(HALF_CLKS + 1);

  logic [BW-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic [HW-1:0] hcnt_q;
  logic          phase_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      left_q   <= '0;
      hcnt_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (clr_i) begin
      left_q   <= '0;
      hcnt_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (load_i && !active_q) begin
      sh_q     <= data_i;
      left_q   <= nclk_i;
      hcnt_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (hcnt_q == HW'(HALF_CLKS - 1)) begin
        hcnt_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          if (left_q == CW'(1)) begin
            active_q <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
            sh_q   <= {sh_q[BW-2:0], 1'b1};
          end
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign cclk_o   = phase_q;
  assign din_o    = sh_q[BW-1];

  // data must not move while the clock is high
  p_din_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));
  // controller never offers a byte while one is in flight
  p_load_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_q);
  // a clear silences the clock on the next cycle
  p_clr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cclk_o);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int CLK_PER_US = 50,
  parameter int HOLD_US    = 400,
  parameter int INIT_TO_US = 4000,
  parameter int DONE_TO_US = 1000,
  parameter int HALF_CLKS  = 2,
  parameter int TAIL_CLKS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       prog_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       fail_o,
  output logic [1:0] err_code_o
);
  import cfg_pkg::*;

  localparam int MAX_A  = (HOLD_US > INIT_TO_US) ? HOLD_US : INIT_TO_US;
  localparam int MAX_US = (MAX_A > DONE_TO_US) ? MAX_A : DONE_TO_US;
  localparam int UW     = $clog2(MAX_US + 1);
  localparam int MAX_N  = (TAIL_CLKS > BYTE_W) ? TAIL_CLKS : BYTE_W;
  localparam int CW     = $clog2(MAX_N + 1);

  cfg_state_e st_q, st_d;
  cfg_err_e   err_q, err_d;
  logic       last_q, last_d, seen_low_q, seen_low_d;
  logic       init_s, done_s;
  logic       tmr_clr, tmr_expired;
  logic [UW-1:0] tmr_limit;
  logic       ser_load, ser_clr, ser_active;
  logic [BYTE_W-1:0] ser_data;
  logic [CW-1:0]     ser_nclk;
  logic       accept;

  cfg_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({init_i, done_i}),
    .q_o   ({init_s, done_s})
  );

  always_comb begin
    unique case (st_q)
      ST_HOLD:  tmr_limit = UW'(HOLD_US);
      ST_CLEAR: tmr_limit = UW'(INIT_TO_US);
      default:  tmr_limit = UW'(DONE_TO_US);
    endcase
  end

  cfg_us_timer #(.CLK_PER_US(CLK_PER_US), .UW(UW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .limit_i  (tmr_limit),
    .expired_o(tmr_expired)
  );

  cfg_serializer #(.HALF_CLKS(HALF_CLKS), .CW(CW)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ser_clr),
    .load_i  (ser_load),
    .data_i  (ser_data),
    .nclk_i  (ser_nclk),
    .active_o(ser_active),
    .cclk_o  (cclk_o),
    .din_o   (din_o)
  );

  assign byte_ready_o = (st_q == ST_LOAD) && !ser_active && !last_q && init_s;
  assign accept       = byte_valid_i && byte_ready_o;
  assign ser_clr      = !((st_q == ST_LOAD) || (st_q == ST_TAIL));
  assign tmr_clr      = (st_d != st_q);

  always_comb begin
    st_d       = st_q;
    err_d      = err_q;
    last_d     = last_q;
    seen_low_d = seen_low_q;
    ser_load   = 1'b0;
    ser_data   = byte_data_i;
    ser_nclk   = CW'(BYTE_W);
    unique case (st_q)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start_i) begin
          st_d       = ST_HOLD;
          err_d      = ERR_NONE;
          last_d     = 1'b0;
          seen_low_d = 1'b0;
        end
      end
      ST_HOLD: if (tmr_expired) st_d = ST_CLEAR;
      ST_CLEAR: begin
        if (!init_s) seen_low_d = 1'b1;
        if (seen_low_q && init_s) begin
          st_d = ST_LOAD;
        end else if (tmr_expired) begin
          st_d  = ST_FAIL;
          err_d = ERR_INIT_TIMEOUT;
        end
      end
      ST_LOAD: begin
        // init loss outranks both byte acceptance and load completion
        if (!init_s) begin
          st_d  = ST_FAIL;
          err_d = ERR_INIT_DROP;
        end else if (accept) begin
          ser_load = 1'b1;
          if (byte_last_i) last_d = 1'b1;
        end else if (last_q && !ser_active) begin
          if (TAIL_CLKS > 0) begin
            ser_load = 1'b1;
            ser_data = '1;
            ser_nclk = CW'(TAIL_CLKS);
            st_d     = ST_TAIL;
          end else begin
            st_d = ST_CHECK;
          end
        end
      end
      ST_TAIL: if (!ser_active) st_d = ST_CHECK;
      ST_CHECK: begin
        if (done_s) begin
          st_d = ST_PASS;
        end else if (tmr_expired) begin
          st_d  = ST_FAIL;
          err_d = ERR_DONE_LOW;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      err_q      <= ERR_NONE;
      last_q     <= 1'b0;
      seen_low_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      err_q      <= err_d;
      last_q     <= last_d;
      seen_low_q <= seen_low_d;
    end
  end

  assign prog_o     = (st_q != ST_CLEAR);
  assign busy_o     = !((st_q == ST_IDLE) || (st_q == ST_PASS) || (st_q == ST_FAIL));
  assign ok_o       = (st_q == ST_PASS);
  assign fail_o     = (st_q == ST_FAIL);
  assign err_code_o = err_q;

  p_hold_before_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_o) |-> $past(tmr_expired));
  p_load_after_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && $past(st_q) == ST_CLEAR) |-> $past(init_s));
  p_ok_needs_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(done_s));
  p_abort_on_init_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && !init_s) |=> (fail_o && err_code_o == 2'd2));
  p_status_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ok_o || fail_o) && !start_i) |=> ($stable(ok_o) && $stable(err_code_o) && !busy_o));
  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !(st_q == ST_HOLD && $past(st_q) != ST_HOLD));
endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int CPU   = 4;
  localparam int HOLD  = 6;
  localparam int ITO   = 20;
  localparam int DTO   = 10;
  localparam int HALF  = 3;
  localparam int TAIL  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, byte_valid_i = 1'b0, byte_last_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic init_i = 1'b1, done_i = 1'b0;
  logic byte_ready_o, prog_o, cclk_o, din_o, busy_o, ok_o, fail_o;
  logic [1:0] err_code_o;

  always #4 clk = ~clk;

  cfg_loader #(.CLK_PER_US(CPU), .HOLD_US(HOLD), .INIT_TO_US(ITO), .DONE_TO_US(DTO),
               .HALF_CLKS(HALF), .TAIL_CLKS(TAIL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
    .init_i(init_i), .done_i(done_i), .prog_o(prog_o), .cclk_o(cclk_o), .din_o(din_o),
    .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .err_code_o(err_code_o));

  int vecs = 0, fails = 0;
  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask
  task automatic chk_rng(string req, int act, int lo, int hi);
    vecs++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // target model configuration (written by stimulus only)
  int m_nb = 0, m_clr_dly = 5, m_done_dly = 2, m_drop_edge = -1;
  bit m_init_never = 0, m_done_ok = 1;
  logic [7:0] snd [0:63];

  // target model state (written by model only)
  logic [7:0] cap [0:63];
  bit cclk_p = 0, prog_p = 1, dropped = 0, rise_din = 0;
  int clr_cnt = 0, n_edges = 0, hi_len = 0, hi_bad = 0, din_bad = 0, tail_bad = 0;
  int acc_bad = 0, acc_n = 0, prog_falls = 0, post_drop = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      init_i = 1'b1;
      done_i = 1'b0;
      cclk_p = 0;
      prog_p = 1;
    end else begin
      if (!prog_o && prog_p) begin
        prog_falls++;
        n_edges = 0; hi_bad = 0; din_bad = 0; tail_bad = 0; acc_bad = 0; acc_n = 0;
        post_drop = 0; dropped = 0; done_i = 1'b0; done_cnt = 0; clr_cnt = 0;
      end
      if (!prog_o) begin
        clr_cnt++;
        init_i = (!m_init_never && clr_cnt > m_clr_dly);
      end
      if (byte_valid_i && byte_ready_o) begin
        acc_n++;
        if (n_edges % 8 != 0) acc_bad++;
      end
      if (cclk_o && !cclk_p) begin
        if (dropped) post_drop++;
        if (n_edges < 8 * m_nb) cap[n_edges / 8][7 - (n_edges % 8)] = din_o;
        else if (din_o !== 1'b1) tail_bad++;
        n_edges++;
        rise_din = din_o;
        hi_len = 1;
        if (m_drop_edge == n_edges) begin
          init_i = 1'b0;
          dropped = 1;
        end
      end else if (cclk_o) begin
        hi_len++;
        if (din_o !== rise_din) din_bad++;
      end
      if (!cclk_o && cclk_p && !fail_o && hi_len != HALF) hi_bad++;
      if (m_done_ok && prog_o && n_edges == 8 * m_nb + TAIL && !done_i) begin
        done_cnt++;
        if (done_cnt > m_done_dly) done_i = 1'b1;
      end
      cclk_p = cclk_o;
      prog_p = prog_o;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  // mode: 0 normal, 1 done never, 2 init never rises, 3 init drop, 4 start while busy
  task automatic run(int nb, int mode, int drop_edge);
    int n, m, k, bad, falls0;
    m_nb = nb;
    m_clr_dly = $urandom_range(5, 40);
    m_done_dly = $urandom_range(0, 20);
    m_drop_edge = (mode == 3) ? drop_edge : -1;
    m_init_never = (mode == 2);
    m_done_ok = (mode != 1);
    for (int i = 0; i < nb; i++) snd[i] = 8'($urandom);
    falls0 = prog_falls;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R10 busy after start", int'(busy_o), 1);
    end while (prog_o && n < 100000);
    chk_rng("R1 hold length", n, HOLD * CPU + 1, HOLD * CPU + 3);
    m = 0;
    while (!prog_o && !fail_o) begin
      @(negedge clk);
      m++;
    end
    if (mode == 2) chk_rng("R8 clear wait", m, ITO * CPU, ITO * CPU + 4);
    else chk_rng("R2 clear length", m, m_clr_dly + 1, m_clr_dly + 8);
    @(posedge clk); #1;
    if (mode != 2) begin
      for (int i = 0; i < nb; i++) begin
        repeat ($urandom_range(0, 3)) begin @(posedge clk); #1; end
        if (mode == 4 && i == 1) begin
          start_i = 1'b1;
          @(posedge clk); #1;
          start_i = 1'b0;
        end
        byte_valid_i = 1'b1;
        byte_data_i = snd[i];
        byte_last_i = (i == nb - 1);
        forever begin
          @(negedge clk);
          if (byte_ready_o || fail_o) break;
        end
        @(posedge clk); #1;
        byte_valid_i = 1'b0;
        byte_last_i = 1'b0;
        if (fail_o) break;
      end
    end
    k = 0;
    while (!ok_o && !fail_o && k < 4000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    case (mode)
      0, 4: begin
        chk("R6 ok", int'(ok_o), 1);
        chk("R6 err code", int'(err_code_o), 0);
        chk("R10 busy cleared", int'(busy_o), 0);
        bad = 0;
        for (int i = 0; i < nb; i++) if (cap[i] !== snd[i]) bad++;
        chk("R4 bytes msb first", bad, 0);
        chk("R5 edge total", n_edges, 8 * nb + TAIL);
        chk("R5 tail din high", tail_bad, 0);
        chk("R3 din held", din_bad, 0);
        chk("R3 high phase length", hi_bad, 0);
        chk("R4 accept on byte boundary", acc_bad, 0);
        chk("R4 accepted count", acc_n, nb);
        if (mode == 4) chk("R11 single clear", prog_falls - falls0, 1);
      end
      1: begin
        chk("R9 fail", int'(fail_o), 1);
        chk("R9 err code", int'(err_code_o), 3);
        chk("R9 edges sent", n_edges, 8 * nb + TAIL);
      end
      2: begin
        chk("R8 fail", int'(fail_o), 1);
        chk("R8 err code", int'(err_code_o), 1);
        chk("R8 no clocks", n_edges, 0);
      end
      default: begin
        chk("R7 fail", int'(fail_o), 1);
        chk("R7 err code", int'(err_code_o), 2);
        chk("R7 no edge after drop", post_drop, 0);
        chk("R7 clock low", int'(cclk_o), 0);
        if (drop_edge == 8 * nb) chk("R7 no tail clocks", n_edges, 8 * nb);
      end
    endcase
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0c0f));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", int'(busy_o), 0);
    chk("R10 reset ok/fail", int'(ok_o | fail_o), 0);
    chk("R10 reset prog", int'(prog_o), 1);
    chk("R10 reset cclk", int'(cclk_o), 0);
    chk("R10 reset ready", int'(byte_ready_o), 0);
    chk("R10 reset err", int'(err_code_o), 0);
    @(posedge clk); #1;

    run(1, 0, -1);
    repeat (20) @(negedge clk);
    chk("R10 ok held", int'(ok_o), 1);
    chk("R10 idle held", int'(busy_o), 0);
    @(posedge clk); #1;
    for (int r = 0; r < 6; r++) run($urandom_range(1, 8), 0, -1);
    run(2, 1, -1);
    run(3, 2, -1);
    run(3, 3, 5);
    run(2, 3, 16);    // drop on the final rising edge of the last byte
    run(4, 4, -1);
    run(5, 0, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule